// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block chooses which of six clock sources feeds the system clock and how far that clock is divided. A configuration write carries a 3-bit source code, a 3-bit power-of-two prescaler code, a 2-bit pre-divider for the 100 MHz internal oscillator, and enable bits for three of the oscillators. A requested source becomes active only after its qualified ready signal has been seen for two sampled cycles in a row. Until then the old source stays in use and a completion flag reads 0.

The whole model runs on one reference clock. The active source is shown as a one-hot select vector. Division is shown as a shift amount, together with a one-cycle enable pulse that a downstream prescaler counts. The fields that were written, the raw per-source ready bits and the completion flag are all exposed as plain status pins. There is no streaming data path, so every port is a plain level signal with no valid/ready handshake.

Top module: `sysclk_switch`

## Requirements
- R1: Source codes map onto `src_onehot` bits as follows: 2 to bit 0 (32 MHz crystal), 3 to bit 1 (8 kHz internal), 4 to bit 2 (100 MHz internal), 5 to bit 3 (7.3725 MHz internal), 6 to bit 4 (32 kHz crystal), 7 to bit 5 (external pin). Exactly one bit is set at all times.
- R2: A write with a source code of 0 or 1 leaves `st_sel`, the active source and `st_switch_done` unchanged. The other fields in that same write still take effect.
- R3: `st_switch_done` is 0 while `st_sel` differs from the active source and 1 when they match.
- R4: A source is qualified when its `rdy_in` bit is 1 and its enable is 1. Sources without an enable bit count as enabled. The active source changes to the requested one on the second consecutive clock edge at which the request is qualified. If a write lands at edge k and the target is already qualified, the switch happens at edge k+2. A single qualified edge followed by an unqualified one does not switch.
- R5: Clearing the target's enable bit while a switch is pending keeps the switch pending, with `st_switch_done` at 0.
- R6: The external pin source counts as ready only while both `rdy_in[5]` and `pin_af_en` are 1. This applies both to `st_src_rdy[5]` and to qualification.
- R7: The shift `div_shift` equals the prescaler code. When the 100 MHz source is active, the pre-divider code is added to it. `tick` pulses for one cycle every 2^`div_shift` cycles.
- R8: When `div_shift` or the active source changes, `tick` is 0 in that cycle and the period count restarts from zero.
- R9: Reset state: source code 5 requested and active, prescaler 0, pre-divider 0, 32 MHz crystal enable 0, 100 MHz enable 0, 7.3725 MHz enable 1, `st_switch_done` 1.
- R10: `st_src_rdy[4:0]` follow `rdy_in[4:0]` in the same cycle, regardless of enables.
- R11: Writing a different valid code while a switch is pending retargets it, and the two-edge count starts over for the new target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Requested source code |
| cfg_presc | input | 3 | Power-of-two prescaler code |
| cfg_hsdiv | input | 2 | 100 MHz pre-divider code |
| cfg_xtal_en | input | 1 | 32 MHz crystal enable |
| cfg_hs_en | input | 1 | 100 MHz oscillator enable |
| cfg_mid_en | input | 1 | 7.3725 MHz oscillator enable |
| rdy_in | input | 6 | Raw ready inputs, bit order as in R1 |
| pin_af_en | input | 1 | Alternate-function enable of the clock pin |
| st_sel | output | 3 | Requested source code held in the register |
| st_presc | output | 3 | Held prescaler code |
| st_hsdiv | output | 2 | Held pre-divider code |
| st_xtal_en | output | 1 | Held 32 MHz enable |
| st_hs_en | output | 1 | Held 100 MHz enable |
| st_mid_en | output | 1 | Held 7.3725 MHz enable |
| st_switch_done | output | 1 | 1 when the active source matches the request |
| st_src_rdy | output | 6 | Per-source ready status |
| src_onehot | output | 6 | Active source select |
| div_shift | output | 4 | Total power-of-two division applied |
| tick | output | 1 | Divided-clock enable pulse |

## Verification
The assertions assume that the ready inputs and `pin_af_en` are level signals that are already synchronous to the reference clock, and that `cfg_we` is a single-cycle strobe. The write fields only need to be valid while the strobe is high. The bench drives every input one time unit after the rising edge and holds it for a whole cycle, so each edge samples one settled value. It also issues writes as one-cycle pulses. Ready inputs are toggled for single cycles on purpose, so that the two-edge rule sees both short pulses and steady levels.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int SRC_W      = 3;
  localparam int N_SRC      = 6;
  localparam int CODE_BASE  = 2;
  localparam int PRE_W      = 3;
  localparam int HSD_W      = 2;
  localparam int HS_IDX     = 2;
  localparam int RESET_CODE = 5;
  localparam int MAX_SHIFT  = (2**PRE_W - 1) + (2**HSD_W - 1);
  localparam int SHIFT_W    = $clog2(MAX_SHIFT + 1);

  function automatic logic code_valid(input logic [SRC_W-1:0] c);
    return c >= SRC_W'(CODE_BASE);
  endfunction

  function automatic logic [N_SRC-1:0] code_to_onehot(input logic [SRC_W-1:0] c);
    logic [N_SRC-1:0] v;
    v = '0;
    for (int i = 0; i < N_SRC; i++)
      if (int'(c) == i + CODE_BASE) v[i] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/sysclk_cfg_reg.sv
module sysclk_cfg_reg
  import sysclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SRC_W-1:0] sel_in,
  input  logic [PRE_W-1:0] presc_in,
  input  logic [HSD_W-1:0] hsdiv_in,
  input  logic             xtal_en_in,
  input  logic             hs_en_in,
  input  logic             mid_en_in,
  output logic [SRC_W-1:0] sel_q,
  output logic [PRE_W-1:0] presc_q,
  output logic [HSD_W-1:0] hsdiv_q,
  output logic             xtal_en_q,
  output logic             hs_en_q,
  output logic             mid_en_q,
  output logic             retarget
);
  assign retarget = we && code_valid(sel_in) && (sel_in != sel_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= SRC_W'(RESET_CODE);
      presc_q   <= '0;
      hsdiv_q   <= '0;
      xtal_en_q <= 1'b0;
      hs_en_q   <= 1'b0;
      mid_en_q  <= 1'b1;
    end else if (we) begin
      if (code_valid(sel_in)) sel_q <= sel_in;
      presc_q   <= presc_in;
      hsdiv_q   <= hsdiv_in;
      xtal_en_q <= xtal_en_in;
      hs_en_q   <= hs_en_in;
      mid_en_q  <= mid_en_in;
    end
  end

  assert_reserved_code_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !code_valid(sel_in)) |=> $stable(sel_q));
endmodule

// File: rtl/sysclk_switch_fsm.sv
module sysclk_switch_fsm
  import sysclk_pkg::*;
#(
  parameter int SYNC_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_W-1:0] req_code,
  input  logic             retarget,
  input  logic [N_SRC-1:0] qual_vec,
  output logic [SRC_W-1:0] act_code,
  output logic             done
);
  localparam int CNT_W = $clog2(SYNC_CYCLES + 1);

  logic [CNT_W-1:0] seen_q;
  logic             pending;
  logic             target_ok;

  assign pending   = (req_code != act_code);
  assign target_ok = |(qual_vec & code_to_onehot(req_code));
  assign done      = !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_code <= SRC_W'(RESET_CODE);
      seen_q   <= '0;
    end else if (retarget) begin
      seen_q <= '0;
    end else if (pending && target_ok) begin
      if (seen_q == CNT_W'(SYNC_CYCLES - 1)) begin
        act_code <= req_code;
        seen_q   <= '0;
      end else begin
        seen_q <= seen_q + 1'b1;
      end
    end else begin
      seen_q <= '0;
    end
  end

  assert_switch_needs_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_code) |-> $past(pending && target_ok));
  assert_retarget_holds_active_R11: assert property (@(posedge clk) disable iff (!rst_n)
    retarget |=> $stable(act_code));
  assert_disabled_target_stays_pending_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !target_ok) |=> $stable(act_code));
endmodule

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler
  import sysclk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRE_W-1:0]   presc,
  input  logic [HSD_W-1:0]   hsdiv,
  input  logic [SRC_W-1:0]   act_code,
  output logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int CW = (MAX_SHIFT > 0) ? MAX_SHIFT : 1;

  logic [CW-1:0]      cnt_q;
  logic [CW-1:0]      limit;
  logic [SHIFT_W-1:0] prev_shift;
  logic [SRC_W-1:0]   prev_act;
  logic               hs_active;
  logic               restart;

  assign hs_active = (act_code == SRC_W'(HS_IDX + CODE_BASE));
  assign shift     = SHIFT_W'(presc) + (hs_active ? SHIFT_W'(hsdiv) : '0);
  assign limit     = CW'((64'd1 << shift) - 64'd1);
  assign restart   = (shift != prev_shift) || (act_code != prev_act);
  assign tick      = !restart && (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      prev_shift <= '0;
      prev_act   <= SRC_W'(RESET_CODE);
    end else begin
      prev_shift <= shift;
      prev_act   <= act_code;
      if (restart || tick) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_no_tick_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(presc) || !$stable(act_code)) |-> !tick);
  assert_no_double_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && shift != '0) |=> !tick);
endmodule

// File: rtl/sysclk_switch.sv
module sysclk_switch
  import sysclk_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cfg_we,
  input  logic [2:0]   cfg_sel,
  input  logic [2:0]   cfg_presc,
  input  logic [1:0]   cfg_hsdiv,
  input  logic         cfg_xtal_en,
  input  logic         cfg_hs_en,
  input  logic         cfg_mid_en,
  input  logic [5:0]   rdy_in,
  input  logic         pin_af_en,
  output logic [2:0]   st_sel,
  output logic [2:0]   st_presc,
  output logic [1:0]   st_hsdiv,
  output logic         st_xtal_en,
  output logic         st_hs_en,
  output logic         st_mid_en,
  output logic         st_switch_done,
  output logic [5:0]   st_src_rdy,
  output logic [5:0]   src_onehot,
  output logic [3:0]   div_shift,
  output logic         tick
);
  localparam int PIN_IDX  = N_SRC - 1;
  localparam int XTAL_IDX = 0;
  localparam int MID_IDX  = 3;

  logic             retarget;
  logic [SRC_W-1:0] act_code;
  logic [N_SRC-1:0] en_vec;
  logic [N_SRC-1:0] qual_vec;

  sysclk_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .sel_in(cfg_sel), .presc_in(cfg_presc), .hsdiv_in(cfg_hsdiv),
    .xtal_en_in(cfg_xtal_en), .hs_en_in(cfg_hs_en), .mid_en_in(cfg_mid_en),
    .sel_q(st_sel), .presc_q(st_presc), .hsdiv_q(st_hsdiv),
    .xtal_en_q(st_xtal_en), .hs_en_q(st_hs_en), .mid_en_q(st_mid_en),
    .retarget(retarget)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    if (i == PIN_IDX) begin : g_pin
      assign st_src_rdy[i] = rdy_in[i] & pin_af_en;
    end else begin : g_plain
      assign st_src_rdy[i] = rdy_in[i];
    end
    if (i == XTAL_IDX) begin : g_en_x
      assign en_vec[i] = st_xtal_en;
    end else if (i == HS_IDX) begin : g_en_h
      assign en_vec[i] = st_hs_en;
    end else if (i == MID_IDX) begin : g_en_m
      assign en_vec[i] = st_mid_en;
    end else begin : g_en_1
      assign en_vec[i] = 1'b1;
    end
    assign qual_vec[i] = st_src_rdy[i] & en_vec[i];
  end

  sysclk_switch_fsm #(.SYNC_CYCLES(2)) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_code(st_sel), .retarget(retarget),
    .qual_vec(qual_vec), .act_code(act_code), .done(st_switch_done)
  );

  assign src_onehot = code_to_onehot(act_code);

  sysclk_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .presc(st_presc), .hsdiv(st_hsdiv),
    .act_code(act_code), .shift(div_shift), .tick(tick)
  );

  assert_onehot_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(src_onehot));
  assert_done_means_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    st_switch_done |-> (src_onehot == code_to_onehot(st_sel)));
endmodule

// File: tb/sysclk_switch_test.sv
`timescale 1ns/1ps
module sysclk_switch_test;
  logic clk = 0, rst_n = 0;
  logic cfg_we = 0;
  logic [2:0] cfg_sel = 0, cfg_presc = 0;
  logic [1:0] cfg_hsdiv = 0;
  logic cfg_xtal_en = 0, cfg_hs_en = 0, cfg_mid_en = 0;
  logic [5:0] rdy_in = 0;
  logic pin_af_en = 0;
  logic [2:0] st_sel, st_presc;
  logic [1:0] st_hsdiv;
  logic st_xtal_en, st_hs_en, st_mid_en, st_switch_done, tick;
  logic [5:0] st_src_rdy, src_onehot;
  logic [3:0] div_shift;

  sysclk_switch uut (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  // reference model state
  int m_req, m_act, m_cnt, m_presc, m_hsdiv, m_xen, m_hen, m_men, m_pc, m_psh, m_pact;
  // shadow of last written fields
  int w_presc = 0, w_hsdiv = 0, w_xen = 0, w_hen = 0, w_men = 1;

  function automatic int m_shift();
    return m_presc + ((m_act == 4) ? m_hsdiv : 0);
  endfunction

  function automatic bit m_rdy(int idx);
    if (idx == 5) return rdy_in[5] && pin_af_en;
    return rdy_in[idx];
  endfunction

  function automatic bit m_qual(int code);
    int idx = code - 2;
    bit en = 1;
    if (idx == 0) en = (m_xen != 0);
    if (idx == 2) en = (m_hen != 0);
    if (idx == 3) en = (m_men != 0);
    return m_rdy(idx) && en;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_req = 5; m_act = 5; m_cnt = 0; m_presc = 0; m_hsdiv = 0;
      m_xen = 0; m_hen = 0; m_men = 1; m_pc = 0; m_psh = 0; m_pact = 5;
    end else begin
      int sh;
      bit rs, tk, rt;
      sh = m_shift();
      rs = (sh != m_psh) || (m_act != m_pact);
      tk = !rs && (m_pc == (1 << sh) - 1);
      if (rs || tk) m_pc = 0; else m_pc++;
      m_psh = sh; m_pact = m_act;
      rt = cfg_we && cfg_sel >= 2 && int'(cfg_sel) != m_req;
      if (rt) m_cnt = 0;
      else if (m_req != m_act && m_qual(m_req)) begin
        if (m_cnt == 1) begin m_act = m_req; m_cnt = 0; end
        else m_cnt++;
      end else m_cnt = 0;
      if (cfg_we) begin
        if (cfg_sel >= 2) m_req = cfg_sel;
        m_presc = cfg_presc; m_hsdiv = cfg_hsdiv;
        m_xen = cfg_xtal_en; m_hen = cfg_hs_en; m_men = cfg_mid_en;
      end
    end
    if (cyc > 100000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int sh, ex1h;
      bit rs, etk;
      sh = m_shift();
      rs = (sh != m_psh) || (m_act != m_pact);
      etk = !rs && (m_pc == (1 << sh) - 1);
      ex1h = 1 << (m_act - 2);
      check(src_onehot == ex1h, "R1 R4 onehot", src_onehot, ex1h);
      check(st_switch_done == (m_req == m_act), "R3 done", st_switch_done, m_req == m_act);
      check(st_sel == m_req, "R2 sel", st_sel, m_req);
      check(st_presc == m_presc && st_hsdiv == m_hsdiv, "R9 fields", {st_presc, st_hsdiv},
            (m_presc << 2) | m_hsdiv);
      check({st_xtal_en, st_hs_en, st_mid_en} == {m_xen[0], m_hen[0], m_men[0]}, "R9 enables",
            {st_xtal_en, st_hs_en, st_mid_en}, m_xen * 4 + m_hen * 2 + m_men);
      check(st_src_rdy == {rdy_in[5] & pin_af_en, rdy_in[4:0]}, "R10 R6 src_rdy",
            st_src_rdy, {rdy_in[5] & pin_af_en, rdy_in[4:0]});
      check(div_shift == sh, "R7 shift", div_shift, sh);
      check(tick == etk, "R8 tick", tick, etk);
    end
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int sel);
    cfg_we = 1; cfg_sel = 3'(sel); cfg_presc = 3'(w_presc); cfg_hsdiv = 2'(w_hsdiv);
    cfg_xtal_en = w_xen[0]; cfg_hs_en = w_hen[0]; cfg_mid_en = w_men[0];
    step();
    cfg_we = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step();
    // R9 reset state explicit
    check(st_sel == 5 && src_onehot == 6'b001000 && st_switch_done, "R9 reset source",
          src_onehot, 8);
    check(!st_xtal_en && !st_hs_en && st_mid_en && st_presc == 0, "R9 reset enables",
          {st_xtal_en, st_hs_en, st_mid_en}, 1);
    rdy_in = 6'b001000;
    step(4);
    // R4: steady ready target, write at edge k -> switch at k+2
    rdy_in = 6'b001011;
    wr(3);
    check(st_switch_done == 0, "R4 pending after write", st_switch_done, 0);
    step();
    check(src_onehot == 6'b001000, "R4 still old source", src_onehot, 8);
    step();
    check(src_onehot == 6'b000010, "R4 switched at k+2", src_onehot, 2);
    // R2: reserved codes ignored, other fields still written
    w_presc = 2;
    wr(0);
    check(st_sel == 3 && st_presc == 2 && st_switch_done, "R2 code 0 ignored", st_sel, 3);
    wr(1);
    check(st_sel == 3 && src_onehot == 6'b000010, "R2 code 1 ignored", st_sel, 3);
    step(10);
    // R5: enable cleared while pending
    rdy_in[2] = 0; w_hen = 1;
    wr(4);
    step(2);
    w_hen = 0;
    wr(3'd0);
    rdy_in[2] = 1;
    step(6);
    check(st_switch_done == 0 && st_sel == 4, "R5 stays pending", st_switch_done, 0);
    // R4 short pulse: enable, glitch ready single cycles
    rdy_in[2] = 0; w_hen = 1;
    wr(0);
    for (int i = 0; i < 4; i++) begin
      rdy_in[2] = 1; step(); rdy_in[2] = 0; step();
    end
    check(src_onehot == 6'b000010, "R4 single-cycle ready no switch", src_onehot, 2);
    rdy_in[2] = 1;
    step(3);
    check(src_onehot == 6'b000100, "R4 switched to 100 MHz", src_onehot, 4);
    // R7 with pre-divider while 100 MHz active
    w_hsdiv = 3; w_presc = 1;
    wr(0);
    step(80);
    check(div_shift == 4, "R7 shift sums pre-divider", div_shift, 4);
    // R6: pin source gated by af enable
    pin_af_en = 0; rdy_in[5] = 1;
    wr(7);
    step(6);
    check(st_switch_done == 0, "R6 pin not ready without af", st_switch_done, 0);
    check(st_src_rdy[5] == 0, "R6 pin status gated", st_src_rdy[5], 0);
    // R11: retarget to 32 kHz crystal while pending
    rdy_in[4] = 0;
    wr(6);
    rdy_in[4] = 1;
    step();
    wr(7);
    pin_af_en = 1;
    step();
    check(src_onehot == 6'b000100, "R11 count restarted", src_onehot, 4);
    step();
    check(src_onehot == 6'b100000, "R11 R6 pin active", src_onehot, 32);
    // R7 R8 prescaler sweep
    for (int p = 0; p < 8; p++) begin
      w_presc = p;
      wr(0);
      step((1 << p) * 3 + 5);
    end
    w_xen = 1; w_presc = 3;
    wr(2);
    step(40);
    w_presc = 7; w_hsdiv = 3; w_men = 1; w_hen = 1;
    wr(4);
    step(3000);
    check(div_shift == 10, "R7 maximum shift", div_shift, 10);
    step(5);
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule